// File: doc/BRIEF.md
# Pipelined Single-Precision Float Multiplier

This block multiplies two 32-bit single-precision operands with normal encodings. It returns the product's sign, its 8-bit biased exponent and the complete 48-bit significand product without rounding. That full product suits a downstream accumulator, which can round once at the end of a multiply-accumulate chain. Three parallel paths compute the product: the sign, the exponent and the significand. A normalizer joins them, and a range check follows it. When the exponent leaves the representable range, the result is forced to zero or infinity, and the sign is kept.

A caller presents an operand pair and raises `inValid` in the same cycle. A new pair may arrive every cycle. Every accepted pair produces one result exactly three clock edges later, marked by `outValid`. There is no back-pressure and no rounding. Encodings with an all-ones exponent are treated as ordinary large exponents.

Top module: `fp32_mul_pipe`

## Requirements
- R1: `resSign` equals the XOR of bit 31 of `opA` and bit 31 of `opB`, for every result, including flushed results.
- R2: For a normal result, `resSig` is the 48-bit product of the two 24-bit significands, each formed by placing a 1 above the 23-bit fraction (bits 22..0). If bit 47 of that product is set, the product is shifted right by one place. Otherwise it is left unchanged. In both cases bit 46 holds the leading one and bit 47 is 0.
- R3: For a normal result, `resExp` equals Ea + Eb − 127, plus 1 when the product was shifted. Ea and Eb are bits 30..23 of each operand. A result is normal when this final value lies in 1..254, and 254 itself is still normal.
- R4: If the final exponent is 255 or more, `ovfFlag` is 1, `unfFlag` is 0, `resExp` is 255 and `resSig` is 0. This covers overflow caused only by the normalization increment.
- R5: If the final exponent is 0 or less, `unfFlag` is 1, `ovfFlag` is 0, and both `resExp` and `resSig` are 0. An intermediate exponent of exactly 0 that gains 1 from the shift becomes a normal result with exponent 1.
- R6: If either operand has exponent field 0 and fraction 0, the result is signed zero with both flags clear. This rule takes priority over R7.
- R7: If either operand has exponent field 0 and a non-zero fraction, and neither operand is zero, the result is signed zero with `unfFlag` set.
- R8: `outValid` rises exactly three clock edges after an accepted pair, and only for accepted pairs. Results leave in the order the pairs arrived, one per cycle when inputs arrive back to back.
- R9: A synchronous reset clears `outValid`, both flags, `resSign`, `resExp` and `resSig` to 0, and it discards every pair in flight.
- R10: `ovfFlag` and `unfFlag` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair present this cycle |
| opA | input | 32 | First operand, single-precision encoding |
| opB | input | 32 | Second operand, single-precision encoding |
| outValid | output | 1 | Result fields valid this cycle |
| resSign | output | 1 | Result sign |
| resExp | output | 8 | Result biased exponent |
| resSig | output | 48 | Unrounded significand product, leading one at bit 46 |
| ovfFlag | output | 1 | Exponent overflow; result is signed infinity |
| unfFlag | output | 1 | Exponent underflow or subnormal operand; result is signed zero |

## Verification
The bench builds the block with its defaults: an 8-bit exponent, a 23-bit fraction, and the split multiplier whose partial products are registered mid-way. With these values, every exponent boundary can be reached with real single-precision encodings. These boundaries are 254 against 255, and an intermediate 0 that is either rescued or not rescued by the shift. The split variant also puts the recombination of the two partial products under test across the stage-one register. Directed pairs cover each corner. A pseudo-random stream with gaps exercises back-to-back throughput and ordering.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

  // Load strobes sent from the control to the datapath, one per register stage
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } pipeStrobes_t;

endpackage

// File: rtl/fpmul_ctrl.sv
module fpmul_ctrl
  import fpmul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output pipeStrobes_t strobes,
  output logic         outValid
);

  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    strobes.ld1 = inValid;
    strobes.ld2 = v1;
    strobes.ld3 = v2;
  end

  assign outValid = v3;

endmodule

// File: rtl/fpmul_datapath.sv
module fpmul_datapath
  import fpmul_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit SPLIT_MUL = 1'b1,
  localparam int WORD_W   = 1 + EXP_W + FRAC_W,
  localparam int SIG_W    = FRAC_W + 1,
  localparam int PROD_W   = 2 * SIG_W
)(
  input  logic              clk,
  input  logic              rst,
  input  pipeStrobes_t      strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              resSign,
  output logic [EXP_W-1:0]  resExp,
  output logic [PROD_W-1:0] resSig,
  output logic              ovfFlag,
  output logic              unfFlag
);

  localparam int IEXP_W = EXP_W + 2;
  localparam int HALF   = SIG_W / 2;
  localparam int HI_W   = SIG_W - HALF;
  localparam logic signed [IEXP_W-1:0] BIAS_S  = IEXP_W'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [IEXP_W-1:0] EXP_TOP = IEXP_W'((2 ** EXP_W) - 1);

  // ---- operand field split ----
  logic [EXP_W-1:0]  expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic [SIG_W-1:0]  sigA, sigB;
  logic              zeroIn, subIn;

  always_comb begin
    expA   = opA[WORD_W-2 -: EXP_W];
    expB   = opB[WORD_W-2 -: EXP_W];
    fracA  = opA[FRAC_W-1:0];
    fracB  = opB[FRAC_W-1:0];
    sigA   = {1'b1, fracA};
    sigB   = {1'b1, fracB};
    zeroIn = ((expA == '0) && (fracA == '0)) || ((expB == '0) && (fracB == '0));
    subIn  = ((expA == '0) && (fracA != '0)) || ((expB == '0) && (fracB != '0));
  end

  // ---- stage 1: sign, class, biased exponent sum ----
  logic             s1Sign, s1Zero, s1Sub;
  logic [EXP_W:0]   s1ExpSum;

  always_ff @(posedge clk) begin
    if (strobes.ld1) begin
      s1Sign   <= opA[WORD_W-1] ^ opB[WORD_W-1];
      s1Zero   <= zeroIn;
      s1Sub    <= subIn;
      s1ExpSum <= {1'b0, expA} + {1'b0, expB};
    end
  end

  // ---- significand multiplier, split or whole ----
  logic [PROD_W-1:0] prodNext;

  generate
    if (SPLIT_MUL) begin : g_split
      logic [SIG_W+HALF-1:0] s1PartLo;
      logic [SIG_W+HI_W-1:0] s1PartHi;

      always_ff @(posedge clk) begin
        if (strobes.ld1) begin
          s1PartLo <= {{HALF{1'b0}}, sigA} * {{SIG_W{1'b0}}, sigB[HALF-1:0]};
          s1PartHi <= {{HI_W{1'b0}}, sigA} * {{SIG_W{1'b0}}, sigB[SIG_W-1:HALF]};
        end
      end

      assign prodNext = {s1PartHi, {HALF{1'b0}}} +
                        {{(PROD_W-SIG_W-HALF){1'b0}}, s1PartLo};
    end else begin : g_whole
      logic [SIG_W-1:0] s1SigA, s1SigB;

      always_ff @(posedge clk) begin
        if (strobes.ld1) begin
          s1SigA <= sigA;
          s1SigB <= sigB;
        end
      end

      assign prodNext = {{SIG_W{1'b0}}, s1SigA} * {{SIG_W{1'b0}}, s1SigB};
    end
  endgenerate

  // ---- stage 2: full product, unbiased intermediate exponent ----
  logic                     s2Sign, s2Zero, s2Sub;
  logic signed [IEXP_W-1:0] s2Exp;
  logic [PROD_W-1:0]        s2Prod;

  always_ff @(posedge clk) begin
    if (strobes.ld2) begin
      s2Sign <= s1Sign;
      s2Zero <= s1Zero;
      s2Sub  <= s1Sub;
      s2Exp  <= $signed({1'b0, s1ExpSum}) - BIAS_S;
      s2Prod <= prodNext;
    end
  end

  // ---- normalizer and range check ----
  logic                     shiftNeeded;
  logic signed [IEXP_W-1:0] expNorm;
  logic [PROD_W-1:0]        sigNorm;
  logic [EXP_W-1:0]         expFinal;
  logic [PROD_W-1:0]        sigFinal;
  logic                     ovfNext, unfNext;

  always_comb begin
    shiftNeeded = s2Prod[PROD_W-1];
    expNorm     = s2Exp + $signed({1'b0, shiftNeeded});
    sigNorm     = shiftNeeded ? {1'b0, s2Prod[PROD_W-1:1]} : s2Prod;
    expFinal    = expNorm[EXP_W-1:0];
    sigFinal    = sigNorm;
    ovfNext     = 1'b0;
    unfNext     = 1'b0;
    if (s2Zero) begin
      expFinal = '0;
      sigFinal = '0;
    end else if (s2Sub) begin
      expFinal = '0;
      sigFinal = '0;
      unfNext  = 1'b1;
    end else if (expNorm[IEXP_W-1] || (expNorm == '0)) begin
      expFinal = '0;
      sigFinal = '0;
      unfNext  = 1'b1;
    end else if (expNorm >= EXP_TOP) begin
      expFinal = '1;
      sigFinal = '0;
      ovfNext  = 1'b1;
    end
  end

  // ---- stage 3: output register ----
  always_ff @(posedge clk) begin
    if (rst) begin
      resSign <= 1'b0;
      resExp  <= '0;
      resSig  <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strobes.ld3) begin
      resSign <= s2Sign;
      resExp  <= expFinal;
      resSig  <= sigFinal;
      ovfFlag <= ovfNext;
      unfFlag <= unfNext;
    end
  end

endmodule

// File: rtl/fp32_mul_pipe.sv
module fp32_mul_pipe
  import fpmul_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit SPLIT_MUL = 1'b1,
  localparam int WORD_W   = 1 + EXP_W + FRAC_W,
  localparam int PROD_W   = 2 * (FRAC_W + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic              resSign,
  output logic [EXP_W-1:0]  resExp,
  output logic [PROD_W-1:0] resSig,
  output logic              ovfFlag,
  output logic              unfFlag
);

  pipeStrobes_t strobes;

  fpmul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fpmul_datapath #(
    .EXP_W     (EXP_W),
    .FRAC_W    (FRAC_W),
    .SPLIT_MUL (SPLIT_MUL)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .resSign (resSign),
    .resExp  (resExp),
    .resSig  (resSig),
    .ovfFlag (ovfFlag),
    .unfFlag (unfFlag)
  );

endmodule

// File: rtl/fpmul_checker.sv
module fpmul_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int PROD_W = 2 * (FRAC_W + 1)
)(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              outValid,
  input logic              resSign,
  input logic [EXP_W-1:0]  resExp,
  input logic [PROD_W-1:0] resSig,
  input logic              ovfFlag,
  input logic              unfFlag
);

  // Saturating count of edges since reset, so that $past never reaches into reset
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  p_sign_r1: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst == 2'd3) && outValid) |->
      (resSign == $past(opA[WORD_W-1] ^ opB[WORD_W-1], 3)));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(ovfFlag && unfFlag));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovfFlag) |-> ((resExp == '1) && (resSig == '0)));

  p_flush_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && unfFlag) |-> ((resExp == '0) && (resSig == '0)));

  p_leading_one_r2: assert property (@(posedge clk) disable iff (rst)
    (outValid && (resExp != '0) && (resExp != '1)) |->
      (!resSig[PROD_W-1] && resSig[PROD_W-2]));

endmodule

bind fp32_mul_pipe fpmul_checker #(
  .EXP_W  (EXP_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .resSign  (resSign),
  .resExp   (resExp),
  .resSig   (resSig),
  .ovfFlag  (ovfFlag),
  .unfFlag  (unfFlag)
);

// File: tb/fp32_mul_pipe_test.sv
module fp32_mul_pipe_test;

  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        sign;
    logic [7:0]  exp;
    logic [47:0] sig;
    logic        ovf;
    logic        unf;
  } res_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid, resSign, ovfFlag, unfFlag;
  logic [7:0]  resExp;
  logic [47:0] resSig;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  res_t  expQ[$];
  int    stampQ[$];
  string tagQ[$];

  fp32_mul_pipe uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .resSign(resSign), .resExp(resExp),
    .resSig(resSig), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference result built from the requirement text
  function automatic res_t model(input logic [31:0] a, input logic [31:0] b);
    res_t r;
    logic [7:0]  ea, eb;
    logic [22:0] fa, fb;
    logic [47:0] p;
    int e;
    ea = a[30:23]; eb = b[30:23];
    fa = a[22:0];  fb = b[22:0];
    r = '0;
    r.sign = a[31] ^ b[31];
    if ((ea == 0 && fa == 0) || (eb == 0 && fb == 0)) begin
      // R6: zero wins, no flag
    end else if (ea == 0 || eb == 0) begin
      r.unf = 1'b1;                          // R7
    end else begin
      p = {24'd0, 1'b1, fa} * {24'd0, 1'b1, fb};
      e = int'(ea) + int'(eb) - 127;
      if (p[47]) begin
        p = p >> 1;
        e = e + 1;
      end
      if (e <= 0) r.unf = 1'b1;              // R5
      else if (e >= 255) begin               // R4
        r.ovf = 1'b1;
        r.exp = 8'hFF;
      end else begin                         // R2, R3
        r.exp = 8'(e);
        r.sig = p;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string exp_s);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp_s);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
    opA = a;
    opB = b;
    inValid = 1'b1;
    expQ.push_back(model(a, b));
    stampQ.push_back(cyc + 3);               // R8: three edges later
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      while (stampQ.size() > 0 && stampQ[0] < cyc) begin
        check(1'b0, {"R8 missing result ", tagQ[0]}, "none", $sformatf("cycle %0d", stampQ[0]));
        void'(expQ.pop_front()); void'(stampQ.pop_front()); void'(tagQ.pop_front());
      end
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected outValid", "1", "0");
        end else begin
          res_t e;
          res_t got;
          int st;
          string tg;
          e = expQ.pop_front(); st = stampQ.pop_front(); tg = tagQ.pop_front();
          got = '{sign: resSign, exp: resExp, sig: resSig, ovf: ovfFlag, unf: unfFlag};
          check(st == cyc, {"R8 latency ", tg}, $sformatf("cycle %0d", cyc), $sformatf("cycle %0d", st));
          check(got == e, tg, $sformatf("%h", got), $sformatf("%h", e));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check(outValid == 1'b0, "R9 outValid after reset", $sformatf("%b", outValid), "0");
    check(!ovfFlag && !unfFlag, "R9 flags after reset", $sformatf("%b%b", ovfFlag, unfFlag), "00");
    check(resExp == 0 && resSig == 0 && !resSign, "R9 data after reset",
          $sformatf("%h/%h", resExp, resSig), "0/0");

    drive(32'h3F800000, 32'h3F800000, "R2 R3 one times one");
    drive(32'h3FC00000, 32'h3FC00000, "R2 R3 shift case 1.5*1.5");
    drive(32'h42200000, 32'hC0F00000, "R1 R2 R3 40 * -7.5");
    drive(32'hBF800000, 32'hC0400000, "R1 neg*neg");
    drive(32'h7F000000, 32'h3F800000, "R3 exponent 254 stays normal");
    drive(32'h7F400000, 32'h3FC00000, "R4 overflow from normalization");
    drive(32'hFF7FFFFF, 32'h7F7FFFFF, "R4 R1 max*max overflow");
    drive(32'h00800000, 32'h00800000, "R5 deep underflow");
    drive(32'h00C00000, 32'h3F400000, "R5 intermediate 0 rescued");
    drive(32'h00800000, 32'h3F000000, "R5 intermediate 0 not rescued");
    drive(32'h00000000, 32'hC0400000, "R6 zero operand");
    drive(32'h80000000, 32'h00000001, "R6 zero beats subnormal");
    drive(32'h00400000, 32'h40000000, "R7 subnormal operand");
    drive(32'h40000000, 32'h807FFFFF, "R7 R1 subnormal negative");
    idle(2);

    // R9: reset flushes pairs in flight
    drive(32'h3F800000, 32'h40000000, "R9 flushed pair");
    drive(32'h40000000, 32'h40000000, "R9 flushed pair");
    rst = 1'b1;
    void'(expQ.pop_back()); void'(stampQ.pop_back()); void'(tagQ.pop_back());
    void'(expQ.pop_back()); void'(stampQ.pop_back()); void'(tagQ.pop_back());
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) begin
      check(outValid == 1'b0, "R9 no result after reset flush", $sformatf("%b", outValid), "0");
      @(negedge clk);
    end

    // Random stream, back to back with occasional gaps (R8 ordering, R10)
    lfsr = 32'h1234ABCD;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      b = {lfsr[31], 2'b01 ^ {lfsr[7], 1'b0}, lfsr[28:0]};
      if (lfsr[3:0] == 4'd0) idle(1);
      drive(a, b, "R1 R2 R3 R4 R5 R8 R10 random");
    end
    idle(8);
    check(expQ.size() == 0, "R8 all results delivered", $sformatf("%0d left", expQ.size()), "0 left");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule